// File: doc/BRIEF.md
# Elastic Fill-Word Buffer

This block moves 40-bit transmission words across two clock domains in a serial-link retimer. Words arrive on the recovered clock with a write strobe and leave on the local reference clock, one word per read cycle. The two clocks run at nominally equal rates but drift apart by a few hundred ppm. The buffer therefore holds a working reserve of a few tens of words and keeps that reserve centred. It discards surplus idle fill words when the reserve runs high and repeats an idle fill word when it runs low. Frame content is never altered.

A word is four 10-bit characters, and the most significant character comes first. In each character, bit 9 is the control flag and bits 7:0 carry the code byte. A fill word is recognised from its first character alone. Compensation only happens inside inter-frame gaps. Each gap keeps at least two idles and loses at most a fixed number of them. Sticky error flags report a buffer that filled or emptied despite compensation. Single-cycle pulses mark each discarded word and each repeated word.

Top module: `fill_word_elastic_buf`

## Requirements
- R1: While reset is held and on the first read cycle after it, `rd_data` carries the fill word {10'h2BC,10'h095,10'h0B5,10'h0B5} and `wr_drop`, `wr_overflow`, `rd_add` and `rd_underflow` are low.
- R2: After reset, the output carries only fill words and nothing is taken from storage until the read-side level reaches START_LVL (32 words).
- R3: While neither error flag is set, every non-fill word appears at `rd_data` exactly once. Such words keep the order they were written in and are bit-exact.
- R4: A fill word is discarded when three conditions hold: the write-side level exceeds HI_MARK (44), at least two fill words of the current gap are already stored, and the gap's budget is not used up. `wr_drop` is high for the single write cycle after the discarded word.
- R5: At most MAX_DROP (4) fill words are discarded per gap, so a gap of N written idles leaves at least max(2, N-4) idles at the output.
- R6: Once reading has started, a fill word is repeated when the read-side level is below LO_MARK (20) and the current output word is a fill word. On such a cycle the read pointer does not move and `rd_add` is high in the same read cycle as the repeated word.
- R7: With equal clock rates and the level inside the band between LO_MARK and HI_MARK, no word is added or discarded.
- R8: A write that would be stored while the buffer holds 2^ADDR_W words sets `wr_overflow`, which stays set until reset.
- R9: If the buffer is empty while reading and the last word output was not a fill word, `rd_data` becomes the fill word and `rd_underflow` sets and stays set until reset.
- R10: Only a word whose bit 39 (control flag) is 1 and whose bits 37:30 equal 8'hBC counts as a fill word. A word with that byte but the flag clear, or with the flag set and another byte, is never discarded or repeated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Recovered (write) clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| wr_en | input | 1 | Write strobe, one word per cycle when high |
| wr_data | input | 40 | Incoming transmission word |
| wr_drop | output | 1 | One-cycle pulse: a fill word was discarded |
| wr_overflow | output | 1 | Sticky: a word was lost to a full buffer |
| rd_clk | input | 1 | Local reference (read) clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| rd_data | output | 40 | Outgoing transmission word, one per read cycle |
| rd_add | output | 1 | High while the current output is a repeated fill word |
| rd_underflow | output | 1 | Sticky: the buffer ran empty after a non-fill word |

## Verification
The assertions assume that both domains are reset together and that a drop pulse is preceded by a fill-word write. They also assume that gaps between frames hold at least six idles, so that the per-gap drop limit is the only bound on discards. The stimulus sends frames of eight words separated by gaps of six or ten fill words. It offsets the write clock by about five percent in each direction, which is far beyond real drift but still within what one gap per frame can absorb. The overflow and underflow runs deliberately break these assumptions: one runs with no gaps and a much faster writer, and the other runs with a writer that simply stops after data.

// File: rtl/efb_pkg.sv
package efb_pkg;
   localparam int unsigned LANE_W = 10;
   localparam int unsigned LANES  = 4;
   localparam int unsigned WORD_W = LANE_W * LANES;

   typedef logic [WORD_W-1:0] word_t;

   // code byte of the comma control character that opens a fill word
   localparam logic [7:0] COMMA_BYTE = 8'hBC;
   // fill word emitted at start-up, on underflow and as reset value
   localparam word_t FILL_WORD = {10'h2BC, 10'h095, 10'h0B5, 10'h0B5};

   // first lane: bit 9 control flag, bits 7:0 code byte
   function automatic logic is_fill(input word_t w);
      return w[WORD_W-1] && (w[WORD_W-3 -: 8] == COMMA_BYTE);
   endfunction
endpackage

// File: rtl/efb_ptr_sync.sv
module efb_ptr_sync #(
   parameter int unsigned W      = 7,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("efb_ptr_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (rst) chain_q <= '0;
      else     chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/efb_wr_side.sv
module efb_wr_side
   import efb_pkg::*;
#(
   parameter int unsigned ADDR_W   = 6,
   parameter int unsigned HI_MARK  = 44,
   parameter int unsigned MAX_DROP = 4,
   parameter int unsigned MIN_KEEP = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              push,
   input  word_t             push_word,
   input  logic [ADDR_W:0]   rd_ptr_gray,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [ADDR_W:0]   wr_ptr_gray,
   output logic              drop_pulse,
   output logic              overflow
);
   localparam int unsigned PW    = ADDR_W + 1;
   localparam int unsigned DEPTH = 1 << ADDR_W;
   localparam int unsigned KW    = $clog2(MIN_KEEP + 1);
   localparam int unsigned DW    = $clog2(MAX_DROP + 1);

   function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
      logic [PW-1:0] b;
      b[PW-1] = g[PW-1];
      for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return b;
   endfunction

   logic [PW-1:0] wr_bin_q, rd_bin, level;
   logic [KW-1:0] kept_q;
   logic [DW-1:0] dropped_q;
   logic          fill_in, full, drop_now, store;

   always_comb begin
      rd_bin   = g2b(rd_ptr_gray);
      level    = wr_bin_q - rd_bin;
      fill_in  = is_fill(push_word);
      full     = (level == PW'(DEPTH));
      drop_now = push && fill_in && (level > PW'(HI_MARK))
               && (kept_q == KW'(MIN_KEEP)) && (dropped_q < DW'(MAX_DROP));
      store    = push && !drop_now && !full;
   end

   assign mem_we   = store;
   assign mem_addr = wr_bin_q[ADDR_W-1:0];

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_bin_q    <= '0;
         wr_ptr_gray <= '0;
         kept_q      <= '0;
         dropped_q   <= '0;
         drop_pulse  <= 1'b0;
         overflow    <= 1'b0;
      end else begin
         drop_pulse <= drop_now;
         if (push && !drop_now && full) overflow <= 1'b1;
         if (store) begin
            wr_bin_q    <= wr_bin_q + PW'(1);
            wr_ptr_gray <= (wr_bin_q + PW'(1)) ^ ((wr_bin_q + PW'(1)) >> 1);
         end
         // gap bookkeeping: any frame word opens a fresh gap
         if (push && !fill_in) begin
            kept_q    <= '0;
            dropped_q <= '0;
         end else if (drop_now) begin
            dropped_q <= dropped_q + DW'(1);
         end else if (store && fill_in && (kept_q != KW'(MIN_KEEP))) begin
            kept_q <= kept_q + KW'(1);
         end
      end
   end
endmodule

// File: rtl/efb_rd_side.sv
module efb_rd_side
   import efb_pkg::*;
#(
   parameter int unsigned ADDR_W    = 6,
   parameter int unsigned LO_MARK   = 20,
   parameter int unsigned START_LVL = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W:0]   wr_ptr_gray,
   input  word_t             mem_word,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [ADDR_W:0]   rd_ptr_gray,
   output word_t             out_word,
   output logic              add_pulse,
   output logic              underflow
);
   localparam int unsigned PW = ADDR_W + 1;

   function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
      logic [PW-1:0] b;
      b[PW-1] = g[PW-1];
      for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return b;
   endfunction

   typedef enum logic [1:0] {ACT_HOLD, ACT_REPEAT, ACT_STARVE, ACT_READ} rd_act_e;

   logic [PW-1:0] rd_bin_q, wr_bin, level;
   logic          running_q;
   rd_act_e       act;

   always_comb begin
      wr_bin = g2b(wr_ptr_gray);
      level  = wr_bin - rd_bin_q;
      // insertion outranks starvation so an idle tail never flags underflow
      if (!running_q)                                          act = ACT_HOLD;
      else if ((level < PW'(LO_MARK)) && is_fill(out_word))    act = ACT_REPEAT;
      else if (level == '0)                                    act = ACT_STARVE;
      else                                                     act = ACT_READ;
   end

   assign mem_addr = rd_bin_q[ADDR_W-1:0];

   always_ff @(posedge clk) begin
      if (rst) begin
         rd_bin_q    <= '0;
         rd_ptr_gray <= '0;
         running_q   <= 1'b0;
         out_word    <= FILL_WORD;
         add_pulse   <= 1'b0;
         underflow   <= 1'b0;
      end else begin
         add_pulse <= 1'b0;
         unique case (act)
            ACT_HOLD: begin
               out_word <= FILL_WORD;
               if (level >= PW'(START_LVL)) running_q <= 1'b1;
            end
            ACT_REPEAT: add_pulse <= 1'b1;
            ACT_STARVE: begin
               out_word  <= FILL_WORD;
               underflow <= 1'b1;
            end
            ACT_READ: begin
               out_word    <= mem_word;
               rd_bin_q    <= rd_bin_q + PW'(1);
               rd_ptr_gray <= (rd_bin_q + PW'(1)) ^ ((rd_bin_q + PW'(1)) >> 1);
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/fill_word_elastic_buf.sv
module fill_word_elastic_buf
   import efb_pkg::*;
#(
   parameter int unsigned ADDR_W      = 6,
   parameter int unsigned HI_MARK     = 44,
   parameter int unsigned LO_MARK     = 20,
   parameter int unsigned START_LVL   = 32,
   parameter int unsigned MAX_DROP    = 4,
   parameter int unsigned MIN_KEEP    = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              wr_clk,
   input  logic              wr_rst,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   output logic              wr_drop,
   output logic              wr_overflow,
   input  logic              rd_clk,
   input  logic              rd_rst,
   output logic [WORD_W-1:0] rd_data,
   output logic              rd_add,
   output logic              rd_underflow
);
   localparam int unsigned DEPTH = 1 << ADDR_W;
   localparam int unsigned PW    = ADDR_W + 1;

   if (ADDR_W < 2 || ADDR_W > 10) begin : g_bad_addr
      $error("fill_word_elastic_buf: ADDR_W out of range");
   end
   if (!(LO_MARK > 0 && LO_MARK < START_LVL && START_LVL < HI_MARK && HI_MARK < DEPTH)) begin : g_bad_marks
      $error("fill_word_elastic_buf: need 0 < LO_MARK < START_LVL < HI_MARK < depth");
   end
   if (MAX_DROP == 0 || MIN_KEEP == 0) begin : g_bad_gap
      $error("fill_word_elastic_buf: MAX_DROP and MIN_KEEP must be nonzero");
   end

   word_t             store_q [DEPTH];
   logic              mem_we;
   logic [ADDR_W-1:0] waddr, raddr;
   logic [PW-1:0]     wptr_g, rptr_g, wptr_g_rd, rptr_g_wr;

   always_ff @(posedge wr_clk) begin
      if (mem_we) store_q[waddr] <= wr_data;
   end

   efb_wr_side #(
      .ADDR_W(ADDR_W), .HI_MARK(HI_MARK), .MAX_DROP(MAX_DROP), .MIN_KEEP(MIN_KEEP)
   ) u_wr (
      .clk(wr_clk), .rst(wr_rst), .push(wr_en), .push_word(wr_data),
      .rd_ptr_gray(rptr_g_wr), .mem_we(mem_we), .mem_addr(waddr),
      .wr_ptr_gray(wptr_g), .drop_pulse(wr_drop), .overflow(wr_overflow)
   );

   efb_ptr_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_w2r (
      .clk(rd_clk), .rst(rd_rst), .d(wptr_g), .q(wptr_g_rd)
   );

   efb_ptr_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_r2w (
      .clk(wr_clk), .rst(wr_rst), .d(rptr_g), .q(rptr_g_wr)
   );

   efb_rd_side #(
      .ADDR_W(ADDR_W), .LO_MARK(LO_MARK), .START_LVL(START_LVL)
   ) u_rd (
      .clk(rd_clk), .rst(rd_rst), .wr_ptr_gray(wptr_g_rd), .mem_word(store_q[raddr]),
      .mem_addr(raddr), .rd_ptr_gray(rptr_g), .out_word(rd_data),
      .add_pulse(rd_add), .underflow(rd_underflow)
   );
endmodule

// File: rtl/efb_checker.sv
module efb_checker
   import efb_pkg::*;
#(
   parameter int unsigned MAX_DROP = 4
) (
   input logic  wr_clk,
   input logic  wr_rst,
   input logic  wr_en,
   input word_t wr_data,
   input logic  wr_drop,
   input logic  wr_overflow,
   input logic  rd_clk,
   input logic  rd_rst,
   input word_t rd_data,
   input logic  rd_add,
   input logic  rd_underflow
);
   // discards seen since the last frame word was written
   logic [7:0] gap_drops;

   always_ff @(posedge wr_clk) begin
      if (wr_rst)                           gap_drops <= '0;
      else if (wr_en && !is_fill(wr_data))  gap_drops <= '0;
      else if (wr_drop)                     gap_drops <= gap_drops + 8'd1;
   end

   // R4: a discard is only ever reported for a fill word that was presented
   assert_drop_on_fill_R4: assert property (@(posedge wr_clk) disable iff (wr_rst)
      wr_drop |-> ($past(wr_en) && is_fill($past(wr_data))));

   // R5: per-gap discard budget
   assert_gap_budget_R5: assert property (@(posedge wr_clk) disable iff (wr_rst)
      gap_drops <= 8'(MAX_DROP));

   // R6: an inserted word repeats the previous output, which is a fill word
   assert_add_repeats_fill_R6: assert property (@(posedge rd_clk) disable iff (rd_rst)
      rd_add |-> ($stable(rd_data) && is_fill(rd_data)));

   // R8: overflow is sticky
   assert_overflow_sticky_R8: assert property (@(posedge wr_clk) disable iff (wr_rst)
      wr_overflow |=> wr_overflow);

   // R9: underflow is sticky
   assert_underflow_sticky_R9: assert property (@(posedge rd_clk) disable iff (rd_rst)
      rd_underflow |=> rd_underflow);
endmodule

bind fill_word_elastic_buf efb_checker #(.MAX_DROP(MAX_DROP)) u_efb_chk (
   .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_data(wr_data),
   .wr_drop(wr_drop), .wr_overflow(wr_overflow),
   .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_data(rd_data),
   .rd_add(rd_add), .rd_underflow(rd_underflow)
);

// File: tb/tb_fill_word_elastic_buf.sv
`timescale 1ns/1ps
module tb_fill_word_elastic_buf;
   import efb_pkg::*;

   logic  wr_clk = 1'b0, rd_clk = 1'b0;
   logic  wr_rst = 1'b1, rd_rst = 1'b1, wr_en = 1'b0;
   word_t wr_data = '0;
   logic  wr_drop, wr_overflow, rd_add, rd_underflow;
   word_t rd_data;

   real wr_half = 5.0;
   int  n_checks = 0, n_errs = 0, wr_seq = 0, min_gap = 2;
   int  mon_checks = 0, mon_errs = 0;
   int  exp_seq = 0, idle_run = 0, adds_seen = 0, drops_seen = 0;
   logic seen_data = 1'b0, mon_en = 1'b0, mon_clear = 1'b1;

   fill_word_elastic_buf dut (
      .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_data(wr_data),
      .wr_drop(wr_drop), .wr_overflow(wr_overflow),
      .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_data(rd_data),
      .rd_add(rd_add), .rd_underflow(rd_underflow)
   );

   always #5 rd_clk = ~rd_clk;
   initial begin
      #3;
      forever #(wr_half) wr_clk = ~wr_clk;
   end

   // frame words: every eighth carries a control flag with a non-comma byte,
   // the rest carry the comma byte with the flag clear (R10 near misses)
   function automatic word_t seq_word(input int n);
      if (n % 8 == 0) return {2'b10, 8'h3C, 30'(n)};
      return {2'b00, 8'hBC, 30'(n)};
   endfunction

   // output monitor: order, integrity and gap length
   always @(negedge rd_clk) begin
      if (mon_clear) begin
         exp_seq = 0; idle_run = 0; seen_data = 1'b0; adds_seen = 0;
      end else begin
         if (rd_add) adds_seen++;
         if (mon_en) begin
            if (is_fill(rd_data)) idle_run++;
            else begin
               mon_checks++;
               if (rd_data !== seq_word(exp_seq)) begin
                  mon_errs++;
                  $display("FAIL R3 R10: word %0d got %h expected %h", exp_seq, rd_data, seq_word(exp_seq));
               end
               if (seen_data && (exp_seq % 8 == 0)) begin
                  mon_checks++;
                  if (idle_run < min_gap) begin
                     mon_errs++;
                     $display("FAIL R5: gap before word %0d got %0d idles expected >= %0d", exp_seq, idle_run, min_gap);
                  end
               end
               seen_data = 1'b1; exp_seq++; idle_run = 0;
            end
         end
      end
   end

   always @(negedge wr_clk) begin
      if (mon_clear) drops_seen = 0;
      else if (wr_drop) drops_seen++;
   end

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_errs++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic put(input word_t w);
      @(negedge wr_clk);
      wr_en = 1'b1; wr_data = w;
   endtask

   task automatic stop_wr();
      @(negedge wr_clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_wait(input int n);
      repeat (n) @(negedge rd_clk);
   endtask

   task automatic send_frame(input int gap);
      for (int i = 0; i < 8; i++) begin put(seq_word(wr_seq)); wr_seq++; end
      for (int g = 0; g < gap; g++) put(FILL_WORD);
   endtask

   task automatic reset_all(input real half);
      wr_en = 1'b0; mon_en = 1'b0; mon_clear = 1'b1;
      wr_rst = 1'b1; rd_rst = 1'b1; wr_half = half; wr_seq = 0;
      repeat (6) @(negedge rd_clk);
      repeat (4) @(negedge wr_clk);
      wr_rst = 1'b0;
      @(negedge rd_clk);
      rd_rst = 1'b0; mon_clear = 1'b0;
   endtask

   task automatic t_reset();
      wr_half = 5.0; wr_rst = 1'b1; rd_rst = 1'b1;
      rd_wait(4);
      check(rd_data === FILL_WORD, "R1 rd_data in reset", longint'(rd_data), longint'(FILL_WORD));
      reset_all(5.0);
      rd_wait(1);
      check(rd_data === FILL_WORD, "R1 rd_data after reset", longint'(rd_data), longint'(FILL_WORD));
      check(rd_add === 1'b0 && rd_underflow === 1'b0, "R1 read flags", {rd_add, rd_underflow}, 0);
      check(wr_drop === 1'b0 && wr_overflow === 1'b0, "R1 write flags", {wr_drop, wr_overflow}, 0);
   endtask

   task automatic t_startup_underflow();
      reset_all(10.0);
      min_gap = 0; mon_en = 1'b1;
      for (int i = 0; i < 20; i++) begin put(seq_word(wr_seq)); wr_seq++; end
      stop_wr();
      rd_wait(80);
      check(exp_seq == 0, "R2 words read below start level", exp_seq, 0);
      check(rd_data === FILL_WORD, "R2 output held at fill", longint'(rd_data), longint'(FILL_WORD));
      check(rd_underflow === 1'b0, "R9 no underflow before start", rd_underflow, 0);
      for (int i = 0; i < 20; i++) begin put(seq_word(wr_seq)); wr_seq++; end
      stop_wr();
      rd_wait(150);
      check(exp_seq == 40, "R3 all startup words delivered", exp_seq, 40);
      check(rd_underflow === 1'b1, "R9 underflow after data tail", rd_underflow, 1);
      check(rd_data === FILL_WORD, "R9 fill word while empty", longint'(rd_data), longint'(FILL_WORD));
   endtask

   task automatic t_balanced();
      reset_all(5.0);
      min_gap = 6; mon_en = 1'b1;
      for (int f = 0; f < 30; f++) send_frame(6);
      for (int i = 0; i < 10; i++) put(FILL_WORD);
      stop_wr();
      rd_wait(20);
      check(drops_seen == 0, "R7 no discards at equal rates", drops_seen, 0);
      check(adds_seen == 0, "R7 no repeats at equal rates", adds_seen, 0);
      rd_wait(120);
      check(exp_seq == 240, "R3 balanced delivery", exp_seq, 240);
      check(wr_overflow === 1'b0 && rd_underflow === 1'b0, "R8 R9 no errors balanced",
            {wr_overflow, rd_underflow}, 0);
   endtask

   task automatic t_fast(input int gap);
      reset_all(4.75);
      min_gap = (gap - 4 > 2) ? gap - 4 : 2; mon_en = 1'b1;
      for (int f = 0; f < 60; f++) send_frame(gap);
      for (int i = 0; i < 40; i++) put(FILL_WORD);
      stop_wr();
      rd_wait(200);
      check(exp_seq == 480, "R3 fast writer delivery", exp_seq, 480);
      check(drops_seen > 0, "R4 fast writer discards fill (expected nonzero)", drops_seen, 1);
      check(wr_overflow === 1'b0, "R8 no overflow with discards", wr_overflow, 0);
      check(rd_underflow === 1'b0, "R9 no underflow fast writer", rd_underflow, 0);
   endtask

   task automatic t_slow();
      reset_all(5.25);
      min_gap = 6; mon_en = 1'b1;
      for (int f = 0; f < 60; f++) send_frame(6);
      for (int i = 0; i < 10; i++) put(FILL_WORD);
      stop_wr();
      check(drops_seen == 0, "R4 slow writer never discards", drops_seen, 0);
      rd_wait(200);
      check(exp_seq == 480, "R3 slow writer delivery", exp_seq, 480);
      check(adds_seen > 0, "R6 slow writer repeats fill (expected nonzero)", adds_seen, 1);
      check(rd_underflow === 1'b0, "R9 no underflow with repeats", rd_underflow, 0);
   endtask

   task automatic t_overflow();
      reset_all(3.5);
      mon_en = 1'b0;
      for (int i = 0; i < 300; i++) begin put(seq_word(wr_seq)); wr_seq++; end
      stop_wr();
      @(negedge wr_clk);
      check(wr_overflow === 1'b1, "R8 overflow set", wr_overflow, 1);
      for (int i = 0; i < 20; i++) put(FILL_WORD);
      stop_wr();
      rd_wait(100);
      check(wr_overflow === 1'b1, "R8 overflow sticky", wr_overflow, 1);
   endtask

   initial begin
      t_reset();
      t_startup_underflow();
      t_balanced();
      t_fast(6);
      t_fast(10);
      t_slow();
      t_overflow();
      $display("Result: errors=%0d of %0d checks", n_errs + mon_errs, n_checks + mon_checks);
      $finish;
   end

   initial begin
      #1_500_000;
      n_errs++; n_checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_errs + mon_errs, n_checks + mon_checks);
      $finish;
   end
endmodule